// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block converts an accepted interrupt type number into the start address of its service routine. A request carries an 8-bit type number and a mode bit. In direct mode the start address is formed arithmetically as a base address plus the type number times a fixed entry spacing; both are parameters. In table mode the unit reads two 16-bit words from a vector table in memory and combines them into a 20-bit physical address. The low word of an entry is an offset, and the high word is a segment. The result is sixteen times the segment plus the offset.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold its request or retry later, because nothing is queued. The memory port uses the same handshake. The unit raises `mem_rd_valid` with a word address, holds both until the memory answers with `mem_rd_ready`, and samples `mem_rdata` on that edge. The memory may stall for any number of cycles. Each result appears as a one-cycle `done` pulse, with the address on `target`.

A separate status group covers interrupt sources that share one vector. Each source has a sticky flag that software clears by writing ones. A group request stays raised while any flag is set.

Top module: `ivec_fetch_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `mem_rd_valid` is 0, all `src_flags` are 0 and `grp_irq` is 0.
- R2: A direct-mode request (`req_indirect`=0) for type n raises `done` on the cycle after acceptance, with `target` = (BASE + n*SPACING) mod 2^20.
- R3: A table-mode request (`req_indirect`=1) for type n reads the byte address 4n first and then 4n+2. `mem_addr` is a 10-bit byte address, so the table spans 0x000 to 0x3FF.
- R4: While `mem_rd_valid` is high and `mem_rd_ready` is low, the unit keeps `mem_rd_valid` high and `mem_addr` unchanged. The unit moves on only on a cycle where `mem_rd_ready` is high.
- R5: In table mode, the first word read is the offset and the second word is the segment. `target` = (16*segment + offset) mod 2^20.
- R6: `done` is high for exactly one clock per accepted request, and `target` is valid while `done` is high.
- R7: `req_ready` is low from the cycle after acceptance until the unit is idle again. A request presented while `req_ready` is low is ignored and produces no `done` pulse.
- R8: A one-cycle pulse on bit i of `src_evt` sets flag i of `src_flags` on the next cycle.
- R9: A cycle with `clr_en`=1 clears every flag whose `clr_mask` bit is 1. If a flag's event pulse arrives in the same cycle as its clear, the flag stays set.
- R10: `grp_irq` is 1 exactly when at least one flag in `src_flags` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_type | input | 8 | Interrupt type number |
| req_indirect | input | 1 | 1 = table mode, 0 = direct mode |
| done | output | 1 | One-cycle result strobe |
| target | output | 20 | Service routine start address, valid while `done` is high |
| mem_rd_valid | output | 1 | Table read request |
| mem_addr | output | 10 | Byte address of the 16-bit word being read |
| mem_rd_ready | input | 1 | Memory answer; `mem_rdata` is valid on this cycle |
| mem_rdata | input | 16 | Word read from the table |
| src_evt | input | 2 | One-cycle event pulses, one per shared source |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 2 | Flags to clear when `clr_en` is high |
| src_flags | output | 2 | Sticky per-source flags |
| grp_irq | output | 1 | Group request, high while any flag is set |

## Verification
The bench builds the unit with BASE = 0xFFC00 and SPACING = 8. With these values, type 0 maps near the top of the address space, type 128 wraps exactly to zero, and type 255 wraps to 0x003F8, so the modulo behaviour of the direct sum is exercised. The table entry for type 255 holds segment 0xFFFF and offset 0x0020, which drives the segment sum past 2^20. The memory model's answer latency changes between zero and several cycles, so table reads are checked both back-to-back and under stall.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int WORD_W = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PHYS_W = WORD_W + SEG_SHIFT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_OFS,
    ST_RD_SEG,
    ST_DONE
  } vstate_e;
endpackage

// File: rtl/ivec_direct_calc.sv
module ivec_direct_calc #(
  parameter int TYPE_W = 8,
  parameter int PA_W = 20,
  parameter logic [PA_W-1:0] BASE = '0,
  parameter int SPACING = 8
) (
  input  logic [TYPE_W-1:0] vec_type,
  output logic [PA_W-1:0]   tgt
);
  localparam int PROD_W = PA_W + TYPE_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] sum;

  always_comb begin
    prod = PROD_W'(vec_type) * PROD_W'(SPACING);
    sum  = PROD_W'(BASE) + prod;
    tgt  = sum[PA_W-1:0];
  end
endmodule

// File: rtl/ivec_table_seq.sv
module ivec_table_seq
  import ivec_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int PA_W = PHYS_W,
  localparam int AW = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] start_type,
  input  logic              start_ind,
  input  logic [PA_W-1:0]   direct_tgt,
  output logic              idle,
  output logic              done,
  output logic [PA_W-1:0]   tgt,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rd_ready,
  input  logic [WORD_W-1:0] mem_rdata
);
  vstate_e           state_q;
  logic [TYPE_W-1:0] type_q;
  logic [WORD_W-1:0] ofs_q;
  logic [PA_W-1:0]   tgt_q;
  logic [PA_W-1:0]   seg_phys;

  always_comb begin
    seg_phys = PA_W'({mem_rdata, {SEG_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      type_q  <= '0;
      ofs_q   <= '0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            type_q <= start_type;
            if (start_ind) begin
              state_q <= ST_RD_OFS;
            end else begin
              tgt_q   <= direct_tgt;
              state_q <= ST_DONE;
            end
          end
        end
        ST_RD_OFS: begin
          if (mem_rd_ready) begin
            ofs_q   <= mem_rdata;
            state_q <= ST_RD_SEG;
          end
        end
        ST_RD_SEG: begin
          if (mem_rd_ready) begin
            tgt_q   <= seg_phys + PA_W'(ofs_q);
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle         = (state_q == ST_IDLE);
    done         = (state_q == ST_DONE);
    tgt          = tgt_q;
    mem_rd_valid = (state_q == ST_RD_OFS) || (state_q == ST_RD_SEG);
    mem_addr     = {type_q, (state_q == ST_RD_SEG), 1'b0};
  end
endmodule

// File: rtl/ivec_share_flags.sv
module ivec_share_flags #(
  parameter int GRP_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_N-1:0] src_evt,
  input  logic             clr_en,
  input  logic [GRP_N-1:0] clr_mask,
  output logic [GRP_N-1:0] flags,
  output logic             any_set
);
  logic [GRP_N-1:0] flags_q;

  for (genvar i = 0; i < GRP_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
      end else if (src_evt[i]) begin
        flags_q[i] <= 1'b1;
      end else if (clr_en && clr_mask[i]) begin
        flags_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    flags   = flags_q;
    any_set = |flags_q;
  end
endmodule

// File: rtl/ivec_fetch_unit.sv
module ivec_fetch_unit
  import ivec_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int GRP_N = 2,
  parameter logic [PHYS_W-1:0] BASE = 20'h00000,
  parameter int SPACING = 8,
  localparam int AW = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TYPE_W-1:0] req_type,
  input  logic              req_indirect,
  output logic              done,
  output logic [PHYS_W-1:0] target,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rd_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [GRP_N-1:0]  src_evt,
  input  logic              clr_en,
  input  logic [GRP_N-1:0]  clr_mask,
  output logic [GRP_N-1:0]  src_flags,
  output logic              grp_irq
);
  logic [PHYS_W-1:0] direct_tgt;
  logic              seq_idle;
  logic              accept;

  always_comb begin
    req_ready = seq_idle;
    accept    = req_valid && seq_idle;
  end

  ivec_direct_calc #(
    .TYPE_W(TYPE_W), .PA_W(PHYS_W), .BASE(BASE), .SPACING(SPACING)
  ) u_direct (
    .vec_type(req_type),
    .tgt(direct_tgt)
  );

  ivec_table_seq #(.TYPE_W(TYPE_W), .PA_W(PHYS_W)) u_seq (
    .clk(clk),
    .rst_n(rst_n),
    .start(accept),
    .start_type(req_type),
    .start_ind(req_indirect),
    .direct_tgt(direct_tgt),
    .idle(seq_idle),
    .done(done),
    .tgt(target),
    .mem_rd_valid(mem_rd_valid),
    .mem_addr(mem_addr),
    .mem_rd_ready(mem_rd_ready),
    .mem_rdata(mem_rdata)
  );

  ivec_share_flags #(.GRP_N(GRP_N)) u_flags (
    .clk(clk),
    .rst_n(rst_n),
    .src_evt(src_evt),
    .clr_en(clr_en),
    .clr_mask(clr_mask),
    .flags(src_flags),
    .any_set(grp_irq)
  );
endmodule

// File: rtl/ivec_fetch_chk.sv
module ivec_fetch_chk #(
  parameter int TYPE_W = 8,
  parameter int GRP_N = 2,
  parameter int PA_W = 20,
  localparam int AW = TYPE_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_indirect,
  input logic              done,
  input logic              mem_rd_valid,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_rd_ready,
  input logic [GRP_N-1:0]  src_evt,
  input logic              clr_en,
  input logic [GRP_N-1:0]  clr_mask,
  input logic [GRP_N-1:0]  src_flags
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (req_ready && !done && !mem_rd_valid && src_flags == '0));

  p_direct_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_indirect) |=> done);

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_addr[0] == 1'b0));

  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_read_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  p_set_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_flags & ~$past(src_flags)) != '0) |-> ($past(src_evt) != '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((src_flags & $past(src_evt)) == $past(src_evt)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((clr_mask & ~src_evt) != '0)) |=>
      ((src_flags & $past(clr_mask & ~src_evt)) == '0));
endmodule

bind ivec_fetch_unit ivec_fetch_chk #(
  .TYPE_W(TYPE_W), .GRP_N(GRP_N), .PA_W(ivec_pkg::PHYS_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_indirect(req_indirect),
  .done(done),
  .mem_rd_valid(mem_rd_valid),
  .mem_addr(mem_addr),
  .mem_rd_ready(mem_rd_ready),
  .src_evt(src_evt),
  .clr_en(clr_en),
  .clr_mask(clr_mask),
  .src_flags(src_flags)
);

// File: tb/ivec_fetch_unit_tb_top.sv
module ivec_fetch_unit_tb_top;
  localparam int TYPE_W = 8;
  localparam int GRP_N = 2;
  localparam logic [19:0] BASE = 20'hFFC00;
  localparam int SPACING = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_type = '0;
  logic        req_indirect = 1'b0;
  logic        done;
  logic [19:0] target;
  logic        mem_rd_valid;
  logic [9:0]  mem_addr;
  logic        mem_rd_ready;
  logic [15:0] mem_rdata;
  logic [1:0]  src_evt = '0;
  logic        clr_en = 1'b0;
  logic [1:0]  clr_mask = '0;
  logic [1:0]  src_flags;
  logic        grp_irq;

  always #4 clk = ~clk;

  ivec_fetch_unit #(
    .TYPE_W(TYPE_W), .GRP_N(GRP_N), .BASE(BASE), .SPACING(SPACING)
  ) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_done = 0;
  int n_push = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [15:0] memw [512];
  int lat = 0;
  int wait_cnt = 0;

  function automatic logic [15:0] f_ofs(input int n);
    if (n == 255) return 16'h0020;
    return 16'(n * 16'h0103 + 16'h0011);
  endfunction

  function automatic logic [15:0] f_seg(input int n);
    if (n == 255) return 16'hFFFF;
    return 16'(16'h1000 + n * 16'h0021);
  endfunction

  initial begin
    for (int n = 0; n < 256; n++) begin
      memw[2*n]   = f_ofs(n);
      memw[2*n+1] = f_seg(n);
    end
  end

  assign mem_rd_ready = mem_rd_valid && (wait_cnt == lat);
  assign mem_rdata    = memw[mem_addr[9:1]];

  always @(posedge clk) begin
    if (!mem_rd_valid || mem_rd_ready) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
    cyc <= cyc + 1;
  end

  // scoreboard
  logic [19:0] exp_q [$];
  int          cur_n = 0;
  bit          seg_phase = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_valid && mem_rd_ready) begin
        check(mem_addr == 10'(cur_n * 4 + (seg_phase ? 2 : 0)),
              seg_phase ? "R3 second read addr" : "R3 first read addr",
              32'(mem_addr), 32'(cur_n * 4 + (seg_phase ? 2 : 0)));
        seg_phase = ~seg_phase;
      end
      if (done) begin
        n_done++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 done with no pending request", 32'(target), 32'h0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(target == e, "R2/R5/R6 target", 32'(target), 32'(e));
        end
      end
    end
  end

  task automatic issue(input int n, input bit ind);
    logic [20:0] full;
    if (ind) full = {1'b0, f_seg(n), 4'h0} + 21'(f_ofs(n));
    else     full = 21'(BASE) + 21'(n * SPACING);
    exp_q.push_back(full[19:0]);
    n_push++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_n = n;
    seg_phase = 1'b0;
    req_valid = 1'b1;
    req_type = 8'(n);
    req_indirect = ind;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    #200000;
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    check(done == 1'b0, "R1 done", 32'(done), 32'h0);
    check(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 32'h0);
    check(src_flags == 2'b00 && grp_irq == 1'b0, "R1 flags", 32'({grp_irq, src_flags}), 32'h0);

    // R2 direct mode, including wraps
    issue(0, 1'b0);
    check(done == 1'b1, "R2 done one cycle after accept", 32'(done), 32'h1);
    drain();
    issue(3, 1'b0);   drain();
    issue(128, 1'b0); drain();
    issue(255, 1'b0); drain();

    // R3 R4 R5 table mode, several latencies
    lat = 0; issue(0, 1'b1);   drain();
    lat = 3; issue(5, 1'b1);   drain();
    lat = 1; issue(200, 1'b1); drain();
    lat = 5; issue(255, 1'b1); drain();

    // R7 request while busy is ignored
    lat = 4;
    issue(7, 1'b1);
    req_valid = 1'b1; req_type = 8'd9; req_indirect = 1'b0;
    check(req_ready == 1'b0, "R7 ready low while busy", 32'(req_ready), 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (6) @(negedge clk);
    check(n_done == n_push, "R7 one done per accepted request", 32'(n_done), 32'(n_push));
    check(req_ready == 1'b1, "R7 ready back when idle", 32'(req_ready), 32'h1);

    // R8 R10 flags set
    src_evt = 2'b01; @(negedge clk); src_evt = 2'b00;
    check(src_flags == 2'b01, "R8 flag0 set", 32'(src_flags), 32'h1);
    check(grp_irq == 1'b1, "R10 irq with one flag", 32'(grp_irq), 32'h1);
    src_evt = 2'b10; @(negedge clk); src_evt = 2'b00;
    check(src_flags == 2'b11, "R8 flag1 set", 32'(src_flags), 32'h3);
    // R9 W1C
    clr_en = 1'b1; clr_mask = 2'b01; @(negedge clk); clr_en = 1'b0; clr_mask = 2'b00;
    check(src_flags == 2'b10, "R9 clear flag0 only", 32'(src_flags), 32'h2);
    check(grp_irq == 1'b1, "R10 irq with remaining flag", 32'(grp_irq), 32'h1);
    // R9 set wins over clear on the same flag
    src_evt = 2'b10; clr_en = 1'b1; clr_mask = 2'b10; @(negedge clk);
    src_evt = 2'b00; clr_en = 1'b0; clr_mask = 2'b00;
    check(src_flags == 2'b10, "R9 set wins over clear", 32'(src_flags), 32'h2);
    clr_en = 1'b1; clr_mask = 2'b11; @(negedge clk); clr_en = 1'b0; clr_mask = 2'b00;
    check(src_flags == 2'b00, "R9 clear all", 32'(src_flags), 32'h0);
    check(grp_irq == 1'b0, "R10 irq low when empty", 32'(grp_irq), 32'h0);
    // R9 clear mask without clr_en has no effect
    src_evt = 2'b01; @(negedge clk); src_evt = 2'b00;
    clr_mask = 2'b01; @(negedge clk); clr_mask = 2'b00;
    check(src_flags == 2'b01, "R9 mask ignored without strobe", 32'(src_flags), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule